// File: doc/BRIEF.md
# Byte-Multiplexed Expansion ROM Reader

This block reads 32-bit words out of an external byte-wide ROM of up to 64 KB whose address arrives over a single 8-bit output port. A request names a word index inside the 64 KB window and a four-bit lane mask. The block fetches the enabled bytes one at a time, packs them into a 32-bit result and reports completion with a one-cycle done pulse.

Each 16-bit byte address is sent in two halves. The upper half goes out first and is marked by an address strobe, so that an external holding register can keep it. The lower half then stays on the port for a programmable number of cycles before the data byte is taken. The upper half is sent again only when it differs from the value last handed to the external holder. Between reads the port, the strobe and the output enable all stay at fixed inactive levels.

Top module: `xrom_reader`

## Requirements
- R1: After reset `rom_oe`, `rom_hstb` and `done` are low and `rom_addr` is 0.
- R2: When the upper address byte must be sent, it is driven for one cycle with `rom_hstb` low, then for one cycle with `rom_hstb` high, then for one more cycle with `rom_hstb` low. `rom_oe` is high throughout, and `rom_addr` is unchanged at both the rising and the falling strobe edge.
- R3: After the upper byte, `rom_addr` carries the lower 8 bits of the byte address with `rom_hstb` low.
- R4: The first read after reset always sends the upper byte. A later read sends it only if its upper byte differs from the one last sent. Otherwise the read starts directly with the lower byte.
- R5: Each lower byte is held for `wait_cfg`+1 cycles and `rom_data` is taken at the end of the last of them. `done` rises 3·h + k·(`wait_cfg`+1) clock edges after the edge that accepts the request. Here h is 1 if the upper byte is sent and 0 otherwise, and k is the number of enabled lanes.
- R6: Lane n reads byte address 4·`req_word`+n and its byte is placed in `rdata[8n+7:8n]`.
- R7: Lanes whose `req_be` bit is 0 are not fetched and read as 0. An all-zero mask completes with `done` and never raises `rom_oe`.
- R8: `done` is high for exactly one cycle, with `rom_oe` low and the assembled word on `rdata`.
- R9: A request made while a read is in progress or while `done` is high is ignored. It starts no later access and produces no later `done`.
- R10: While `rom_oe` is low, `rom_addr` is 0 and `rom_hstb` is low. `rom_oe` is high only while a fetch is in progress.
- R11: `rom_data` is ignored while `rom_oe` is low.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Read request, sampled only while idle |
| req_word | input | 14 | Word index of the 32-bit word within the ROM window |
| req_be | input | 4 | Lane mask, bit n selects byte n |
| wait_cfg | input | 4 | Extra cycles each lower address byte is held before sampling |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled word, valid while done is high |
| rom_addr | output | 8 | Multiplexed ROM address port |
| rom_hstb | output | 1 | High while the port carries the upper byte for the external holder |
| rom_oe | output | 1 | ROM output enable, active high |
| rom_data | input | 8 | Byte returned by the ROM |

## Verification
The done pulse is due a fixed number of edges after the accepting edge, set by the formula in R5. The bench counts falling edges from the one right after that edge and expects `done` at count 1 + 3·h + k·(`wait_cfg`+1). It keeps its own copy of the last upper byte sent to decide h. A bench monitor samples the outputs at every falling edge, halfway between register updates. It records each strobe pulse, checks that the port is stable at both strobe edges, and checks that the port is parked whenever the enable is low. The word is compared on the done cycle itself, and `done` is checked to be low again one cycle later.

// File: rtl/xrom_pkg.sv
package xrom_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HSET,
        ST_HSTB,
        ST_HHLD,
        ST_LOW,
        ST_DONE
    } xrom_st_e;
endpackage

// File: rtl/xrom_lane_pick.sv
module xrom_lane_pick #(
    parameter int LANES  = 4,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic [LANES-1:0]  mask,
    output logic              any,
    output logic [LANE_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (mask[i]) begin
                any = 1'b1;
                idx = LANE_W'(i);
            end
        end
    end
endmodule

// File: rtl/xrom_wait_ctr.sv
module xrom_wait_ctr #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [WAIT_W-1:0] limit,
    output logic              hit
);
    logic [WAIT_W-1:0] cnt_d, cnt_q;

    assign hit = (cnt_q == limit);

    always_comb begin
        if (restart)  cnt_d = '0;
        else if (hit) cnt_d = cnt_q;
        else          cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5: a restart always leaves the count at zero on the next cycle
    a_r5_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0))
        else $error("a_r5_restart_zero");
endmodule

// File: rtl/xrom_assemble.sv
module xrom_assemble #(
    parameter int LANES  = 4,
    parameter int PORT_W = 8,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      wr,
    input  logic [LANE_W-1:0]         lane,
    input  logic [PORT_W-1:0]         byte_in,
    output logic [LANES*PORT_W-1:0]   word
);
    logic [LANES*PORT_W-1:0] word_d, word_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            if (clear)
                word_d[g*PORT_W +: PORT_W] = '0;
            else if (wr && lane == LANE_W'(g))
                word_d[g*PORT_W +: PORT_W] = byte_in;
            else
                word_d[g*PORT_W +: PORT_W] = word_q[g*PORT_W +: PORT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign word = word_q;

    // R7: a new request starts from an all-zero word
    a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (word_q == '0))
        else $error("a_r7_clear_zero");
endmodule

// File: rtl/xrom_reader.sv
module xrom_reader
    import xrom_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PORT_W = 8,
    parameter int LANES  = 4,
    parameter int WAIT_W = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    input  logic [ADDR_W-$clog2(LANES)-1:0] req_word,
    input  logic [LANES-1:0]               req_be,
    input  logic [WAIT_W-1:0]              wait_cfg,
    output logic                           done,
    output logic [LANES*PORT_W-1:0]        rdata,
    output logic [PORT_W-1:0]              rom_addr,
    output logic                           rom_hstb,
    output logic                           rom_oe,
    input  logic [PORT_W-1:0]              rom_data
);
    localparam int LANE_W  = $clog2(LANES);
    localparam int WORD_AW = ADDR_W - LANE_W;
    localparam int LO_KEEP = PORT_W - LANE_W;

    typedef struct packed {
        xrom_st_e             st;
        logic [WORD_AW-1:0]   base;
        logic [LANES-1:0]     mask;
        logic [LANE_W-1:0]    lane;
        logic [WAIT_W-1:0]    waitv;
        logic [PORT_W-1:0]    hi_last;
        logic                 hi_ok;
        logic [PORT_W-1:0]    port;
        logic                 stb;
        logic                 oe;
        logic                 done;
    } regs_t;

    regs_t r_d, r_q;

    logic [LANES-1:0]  pick_in, rem, cur_bit;
    logic              pick_any, hit, restart, asm_clear, asm_wr;
    logic [LANE_W-1:0] pick_idx;

    function automatic logic [PORT_W-1:0] hi_of(input logic [WORD_AW-1:0] b);
        return b[WORD_AW-1:LO_KEEP];
    endfunction

    function automatic logic [PORT_W-1:0] low_of(input logic [WORD_AW-1:0] b,
                                                  input logic [LANE_W-1:0]  l);
        return {b[LO_KEEP-1:0], l};
    endfunction

    assign cur_bit = {{(LANES-1){1'b0}}, 1'b1} << r_q.lane;
    assign rem     = r_q.mask & ~cur_bit;
    assign pick_in = (r_q.st == ST_IDLE) ? req_be : rem;

    xrom_lane_pick #(.LANES(LANES), .LANE_W(LANE_W)) u_pick (
        .mask (pick_in),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    xrom_wait_ctr #(.WAIT_W(WAIT_W)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .limit   (r_q.waitv),
        .hit     (hit)
    );

    xrom_assemble #(.LANES(LANES), .PORT_W(PORT_W), .LANE_W(LANE_W)) u_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (asm_clear),
        .wr      (asm_wr),
        .lane    (r_q.lane),
        .byte_in (rom_data),
        .word    (rdata)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        restart   = 1'b0;
        asm_clear = 1'b0;
        asm_wr    = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.base  = req_word;
                    r_d.mask  = req_be;
                    r_d.waitv = wait_cfg;
                    asm_clear = 1'b1;
                    if (!pick_any) begin
                        r_d.st   = ST_DONE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.lane = pick_idx;
                        r_d.oe   = 1'b1;
                        if (r_q.hi_ok && r_q.hi_last == hi_of(req_word)) begin
                            r_d.st   = ST_LOW;
                            r_d.port = low_of(req_word, pick_idx);
                            restart  = 1'b1;
                        end else begin
                            r_d.st      = ST_HSET;
                            r_d.port    = hi_of(req_word);
                            r_d.hi_last = hi_of(req_word);
                            r_d.hi_ok   = 1'b1;
                        end
                    end
                end
            end
            ST_HSET: begin
                r_d.st  = ST_HSTB;
                r_d.stb = 1'b1;
            end
            ST_HSTB: begin
                r_d.st  = ST_HHLD;
                r_d.stb = 1'b0;
            end
            ST_HHLD: begin
                r_d.st   = ST_LOW;
                r_d.port = low_of(r_q.base, r_q.lane);
                restart  = 1'b1;
            end
            ST_LOW: begin
                if (hit) begin
                    asm_wr   = 1'b1;
                    r_d.mask = rem;
                    if (pick_any) begin
                        r_d.lane = pick_idx;
                        r_d.port = low_of(r_q.base, pick_idx);
                        restart  = 1'b1;
                    end else begin
                        r_d.st   = ST_DONE;
                        r_d.done = 1'b1;
                        r_d.oe   = 1'b0;
                        r_d.port = '0;
                    end
                end
            end
            ST_DONE: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign done     = r_q.done;
    assign rom_addr = r_q.port;
    assign rom_hstb = r_q.stb;
    assign rom_oe   = r_q.oe;

    // R10: parked port and strobe whenever the enable is low
    a_r10_park: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_oe |-> (rom_addr == '0 && !rom_hstb))
        else $error("a_r10_park");

    // R2: strobe only inside a read, one cycle wide
    a_r2_stb_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        rom_hstb |-> rom_oe)
        else $error("a_r2_stb_in_read");

    a_r2_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        rom_hstb |=> !rom_hstb)
        else $error("a_r2_stb_single");

    // R2: address stable across both strobe edges
    a_r2_rise_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rom_hstb) |-> $stable(rom_addr))
        else $error("a_r2_rise_stable");

    a_r2_fall_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rom_hstb) |-> $stable(rom_addr))
        else $error("a_r2_fall_stable");

    // R8: one-cycle done with the enable released
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("a_r8_done_pulse");

    a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rom_oe)
        else $error("a_r8_done_quiet");
endmodule

// File: tb/xrom_reader_test.sv
`timescale 1ns/1ps
module xrom_reader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [13:0] req_word = '0;
    logic [3:0]  req_be = '0;
    logic [3:0]  wait_cfg = '0;
    logic        done;
    logic [31:0] rdata;
    logic [7:0]  rom_addr;
    logic        rom_hstb;
    logic        rom_oe;
    logic [7:0]  rom_data;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    logic [7:0] hi_lat = '0;
    logic [7:0] junk = 8'h11;
    logic [7:0] p_port = '0;
    logic       p_stb = 1'b0, p_oe = 1'b0;
    int         stb_cnt = 0, oe_cnt = 0;
    bit         stb_err = 0, park_err = 0;
    logic [7:0] bhi = '0;
    bit         bhi_ok = 0;

    always #2 clk = ~clk;

    xrom_reader uut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_word (req_word),
        .req_be (req_be), .wait_cfg (wait_cfg), .done (done), .rdata (rdata),
        .rom_addr (rom_addr), .rom_hstb (rom_hstb), .rom_oe (rom_oe), .rom_data (rom_data)
    );

    function automatic logic [7:0] rom_fn(input logic [15:0] a);
        return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'h5C;
    endfunction

    // R11: ROM model returns changing junk whenever the enable is low
    assign rom_data = rom_oe ? rom_fn({hi_lat, rom_addr}) : junk;

    always @(posedge clk) junk <= junk + 8'h3B;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rom_hstb && !p_stb) begin
                stb_cnt++;
                if (!p_oe || p_port != rom_addr) stb_err = 1;
            end
            if (!rom_hstb && p_stb && (rom_addr != p_port || !rom_oe)) stb_err = 1;
            if (!rom_oe && (rom_addr != 8'h00 || rom_hstb)) park_err = 1;
            if (rom_oe) oe_cnt++;
            if (rom_hstb) hi_lat = rom_addr;
        end
        p_port = rom_addr;
        p_stb  = rom_hstb;
        p_oe   = rom_oe;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [15:0] addr, input logic [3:0] be,
                           input logic [3:0] w);
        bit          exp_hi;
        int          k, exp_n, n, s0, o0;
        logic [31:0] exp_w;
        exp_hi = (be != 0) && !(bhi_ok && bhi == addr[15:8]);
        if (be != 0) begin bhi = addr[15:8]; bhi_ok = 1; end
        k = $countones(be);
        exp_n = 1 + (exp_hi ? 3 : 0) + k * (w + 1);
        exp_w = '0;
        for (int i = 0; i < 4; i++)
            if (be[i]) exp_w[8*i +: 8] = rom_fn({addr[15:2], 2'(i)});
        s0 = stb_cnt;
        o0 = oe_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_word = addr[15:2]; req_be = be; wait_cfg = w;
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        while (!done && n < 500) begin @(negedge clk); n++; end
        chk(n == exp_n, "R5 latency", 32'(n), 32'(exp_n));
        chk(rdata == exp_w, "R6/R3/R11 word", rdata, exp_w);
        chk(stb_cnt - s0 == (exp_hi ? 1 : 0), "R4 strobe count",
            32'(stb_cnt - s0), exp_hi ? 32'd1 : 32'd0);
        if (be == 4'b0000)
            chk(oe_cnt == o0, "R7 no access on empty mask", 32'(oe_cnt - o0), 32'd0);
        chk(!rom_oe, "R8 enable low with done", 32'(rom_oe), 32'd0);
        @(negedge clk);
        chk(!done, "R8 single-cycle done", 32'(done), 32'd0);
    endtask

    task automatic test_busy_ignored();
        int          n, o0;
        logic [31:0] exp_w;
        bit          extra;
        exp_w = '0;
        for (int i = 0; i < 4; i++) exp_w[8*i +: 8] = rom_fn({14'h1000, 2'(i)});
        bhi = 8'h40; bhi_ok = 1;
        @(negedge clk);
        req_valid = 1'b1; req_word = 14'h1000; req_be = 4'hF; wait_cfg = 4'd5;
        @(negedge clk);
        req_word = 14'h1400; req_be = 4'h3; wait_cfg = 4'd0;
        n = 1;
        while (!done && n < 500) begin @(negedge clk); n++; end
        chk(n == 1 + 3 + 4 * 6, "R9 latency of first request", 32'(n), 32'd28);
        chk(rdata == exp_w, "R9 word from first request", rdata, exp_w);
        @(negedge clk);
        req_valid = 1'b0;
        o0 = oe_cnt;
        extra = 0;
        for (int i = 0; i < 8; i++) begin @(negedge clk); if (done) extra = 1; end
        chk(oe_cnt == o0, "R9 no access after busy request", 32'(oe_cnt - o0), 32'd0);
        chk(!extra, "R9 no later done", 32'(extra), 32'd0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(!rom_oe && !rom_hstb && !done && rom_addr == 0, "R1 reset outputs",
            {rom_oe, rom_hstb, done, 21'b0, rom_addr}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rom_oe && !done && rom_addr == 0, "R1 idle after release",
            {rom_oe, done, 22'b0, rom_addr}, 32'd0);
        do_read(16'h1234, 4'hF, 4'd0);
        do_read(16'h1238, 4'hF, 4'd2);
        do_read(16'h8000, 4'hF, 4'd3);
        do_read(16'h80F0, 4'b1010, 4'd1);
        do_read(16'h80F4, 4'b0000, 4'd7);
        do_read(16'hFFFC, 4'hF, 4'd15);
        do_read(16'hFFF0, 4'b0001, 4'd0);
        test_busy_ignored();
        chk(!stb_err, "R2 port stable at strobe edges", 32'(stb_err), 32'd0);
        chk(!park_err, "R10 port parked while enable low", 32'(park_err), 32'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule